// File: doc/BRIEF.md
# High-Speed Burst Lane Timing Sequencer

This block schedules the line-state changes of one clock lane and a group of data lanes in a serial camera-style transmitter. It sequences each high-speed burst from low-power idle into high-speed transmission and back. The serializer and the line drivers sit outside the block. They consume the two three-bit lane codes that the block emits each byte-clock cycle and the payload word that it registers.

After reset the block holds off all traffic for a programmable slave-initialization count. It then raises a done flag that stays high. A packet source asks for a burst by raising a request. The sequencer walks the lanes through prepare, zero and (for the clock) pre-run intervals. Only then does it assert ready, and it accepts payload words until one is marked last. Each entry and exit interval is its own byte-clock count. The clock lane either runs high-speed without a break (continuous mode) or is stopped between bursts (gated mode). The mode input is held constant while out of reset.

Top module: `dphy_tx_sequencer`

## Requirements
- R1: The init-done output rises at the N-th rising clock edge after reset release, where N is the initialization setting (0 acts as 1), and then stays high. Before that, ready is low, both lanes show LP-11 and requests are ignored.
- R2: The lane codes are 0 = LP-11, 1 = LP-00, 2 = HS-0, 3 = HS data, 4 = HS trail and 5 = HS clock running.
- R3: In gated mode a request seen in idle drives the clock lane to LP-00 for the prepare count, then HS-0 for the zero count, then HS clock for the clock-pre count. The data lane leaves LP-11 only after this, and the clock lane shows HS clock whenever the data lane is not LP-11.
- R4: The data lane shows LP-00 for the prepare count, then HS-0 for the zero count, then HS data.
- R5: Ready is high only while the data lane is in HS data. A word offered with valid while ready is high appears on the transmit data output, with the strobe high, in the following cycle.
- R6: A word accepted with last starts the data-lane trail for the trail count, after which the data lane returns to LP-11. In gated mode the clock lane then keeps HS clock for the clock-post count, shows HS trail for the trail count and returns to LP-11.
- R7: In continuous mode, once init is done, the clock lane passes through LP-00 (prepare count) and HS-0 (zero count) and then stays at HS clock from then on. A request seen in idle starts data-lane prepare at the next edge, and the exit has no clock-post or clock-trail stage.
- R8: A request that is high during the trail or clock-post interval has no effect until the lanes have spent one cycle at LP-11 in idle. The full entry sequence then starts again.
- R9: A timing setting of 0 behaves as 1 byte clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_cont_clk | input | 1 | 1 = continuous clock lane, 0 = gated between bursts |
| cfg_init_cycles | input | INIT_W | Slave-initialization hold in byte clocks |
| cfg_prep | input | CNT_W | Prepare interval (LP-00) |
| cfg_zero | input | CNT_W | Zero interval (HS-0) |
| cfg_clk_pre | input | CNT_W | Clock run time before data-lane entry |
| cfg_clk_post | input | CNT_W | Clock run time after data-lane trail |
| cfg_trail | input | CNT_W | Trail interval for both lanes |
| pkt_req | input | 1 | Burst request from the packet source |
| pkt_valid | input | 1 | Payload word valid |
| pkt_last | input | 1 | Payload word is the last of the burst |
| pkt_data | input | 8*LANES | Payload word |
| pkt_ready | output | 1 | Sequencer accepts payload |
| tx_data | output | 8*LANES | Registered payload to the serializer |
| tx_strobe | output | 1 | tx_data holds a new word |
| clk_lane | output | 3 | Clock-lane line-state code |
| dat_lane | output | 3 | Data-lane line-state code |
| init_done | output | 1 | Initialization hold has expired |

## Verification
Some rules are checked by the assertions on every cycle. Ready and lane activity stay off before init, and init-done never falls. Ready appears only with HS data under a running clock, and HS-0 is always entered from LP-00. The LP-00 run of the data lane has exactly the prepare length. A trail only ever goes back to LP-11, a continuous clock never stops, and an accepted word is always followed by a strobe. Other behaviour can only be shown by the bench's scenarios, through a cycle-exact reference model. That covers the exact position of each interval, the one idle cycle before a held request restarts entry, the zero-as-one settings, the clock-post and clock-trail ordering, and the payload that travels through during a bubble in valid.

// File: rtl/dphy_seq_pkg.sv
package dphy_seq_pkg;

  typedef enum logic [2:0] {
    LN_LP11   = 3'd0,
    LN_LP00   = 3'd1,
    LN_HS0    = 3'd2,
    LN_HSDATA = 3'd3,
    LN_TRAIL  = 3'd4,
    LN_HSCLK  = 3'd5
  } lane_code_e;

  typedef enum logic [3:0] {
    SQ_INIT,
    SQ_IDLE,
    SQ_CK_PREP,
    SQ_CK_ZERO,
    SQ_CK_PRE,
    SQ_D_PREP,
    SQ_D_ZERO,
    SQ_D_HS,
    SQ_D_TRAIL,
    SQ_CK_POST,
    SQ_CK_TRAIL
  } seq_state_e;

  // A setting of S byte clocks loads the down-counter with S-1; S = 0 acts as 1.
  function automatic logic [15:0] span_to_load(input logic [15:0] span);
    return (span == 16'd0) ? 16'd0 : span - 16'd1;
  endfunction

  // Initialization expires once the elapsed count reaches the setting.
  function automatic logic init_reached(input logic [16:0] elapsed, input logic [16:0] setting);
    return elapsed >= setting;
  endfunction

endpackage

// File: rtl/seq_init_hold.sv
module seq_init_hold #(
  parameter int INIT_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [INIT_W-1:0] cfg_cycles,
  output logic              done
);
  import dphy_seq_pkg::*;

  logic [INIT_W-1:0] elapsed_q;
  logic [INIT_W:0]   elapsed_next;

  assign elapsed_next = {1'b0, elapsed_q} + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elapsed_q <= '0;
      done      <= 1'b0;
    end else if (!done) begin
      if (init_reached(17'(elapsed_next), 17'(cfg_cycles)))
        done <= 1'b1;
      else
        elapsed_q <= elapsed_next[INIT_W-1:0];
    end
  end

endmodule

// File: rtl/seq_interval_timer.sv
module seq_interval_timer #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      left_q <= '0;
    else if (load)
      left_q <= load_val;
    else if (left_q != '0)
      left_q <= left_q - 1'b1;
  end

  assign expired = (left_q == '0);

endmodule

// File: rtl/seq_lane_ctrl.sv
module seq_lane_ctrl #(
  parameter int CNT_W = 7
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cont_clk,
  input  logic [CNT_W-1:0]          cfg_prep,
  input  logic [CNT_W-1:0]          cfg_zero,
  input  logic [CNT_W-1:0]          cfg_clk_pre,
  input  logic [CNT_W-1:0]          cfg_clk_post,
  input  logic [CNT_W-1:0]          cfg_trail,
  input  logic                      init_done,
  input  logic                      req,
  input  logic                      burst_done,
  input  logic                      interval_over,
  output dphy_seq_pkg::seq_state_e  state,
  output logic                      timer_load,
  output logic [CNT_W-1:0]          timer_val
);
  import dphy_seq_pkg::*;

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] span;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SQ_INIT:     if (init_done)     state_d = cont_clk ? SQ_CK_PREP : SQ_IDLE;
      SQ_IDLE:     if (req)           state_d = cont_clk ? SQ_D_PREP : SQ_CK_PREP;
      SQ_CK_PREP:  if (interval_over) state_d = SQ_CK_ZERO;
      SQ_CK_ZERO:  if (interval_over) state_d = cont_clk ? SQ_IDLE : SQ_CK_PRE;
      SQ_CK_PRE:   if (interval_over) state_d = SQ_D_PREP;
      SQ_D_PREP:   if (interval_over) state_d = SQ_D_ZERO;
      SQ_D_ZERO:   if (interval_over) state_d = SQ_D_HS;
      SQ_D_HS:     if (burst_done)    state_d = SQ_D_TRAIL;
      SQ_D_TRAIL:  if (interval_over) state_d = cont_clk ? SQ_IDLE : SQ_CK_POST;
      SQ_CK_POST:  if (interval_over) state_d = SQ_CK_TRAIL;
      SQ_CK_TRAIL: if (interval_over) state_d = SQ_IDLE;
      default:                        state_d = SQ_INIT;
    endcase
  end

  always_comb begin
    unique case (state_d)
      SQ_CK_PREP, SQ_D_PREP:   span = cfg_prep;
      SQ_CK_ZERO, SQ_D_ZERO:   span = cfg_zero;
      SQ_CK_PRE:               span = cfg_clk_pre;
      SQ_CK_POST:              span = cfg_clk_post;
      SQ_D_TRAIL, SQ_CK_TRAIL: span = cfg_trail;
      default:                 span = '0;
    endcase
  end

  assign timer_load = (state_d != state_q);
  assign timer_val  = CNT_W'(span_to_load(16'(span)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SQ_INIT;
    else        state_q <= state_d;
  end

  assign state = state_q;

endmodule

// File: rtl/seq_lane_encode.sv
module seq_lane_encode (
  input  dphy_seq_pkg::seq_state_e state,
  input  logic                     cont_clk,
  output dphy_seq_pkg::lane_code_e clk_code,
  output dphy_seq_pkg::lane_code_e dat_code
);
  import dphy_seq_pkg::*;

  always_comb begin
    unique case (state)
      SQ_INIT:     clk_code = LN_LP11;
      SQ_IDLE:     clk_code = cont_clk ? LN_HSCLK : LN_LP11;
      SQ_CK_PREP:  clk_code = LN_LP00;
      SQ_CK_ZERO:  clk_code = LN_HS0;
      SQ_CK_TRAIL: clk_code = LN_TRAIL;
      default:     clk_code = LN_HSCLK;
    endcase
  end

  always_comb begin
    unique case (state)
      SQ_D_PREP:  dat_code = LN_LP00;
      SQ_D_ZERO:  dat_code = LN_HS0;
      SQ_D_HS:    dat_code = LN_HSDATA;
      SQ_D_TRAIL: dat_code = LN_TRAIL;
      default:    dat_code = LN_LP11;
    endcase
  end

endmodule

// File: rtl/dphy_tx_sequencer.sv
module dphy_tx_sequencer #(
  parameter int LANES  = 4,
  parameter int CNT_W  = 7,
  parameter int INIT_W = 15,
  localparam int DW    = 8 * LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_cont_clk,
  input  logic [INIT_W-1:0] cfg_init_cycles,
  input  logic [CNT_W-1:0]  cfg_prep,
  input  logic [CNT_W-1:0]  cfg_zero,
  input  logic [CNT_W-1:0]  cfg_clk_pre,
  input  logic [CNT_W-1:0]  cfg_clk_post,
  input  logic [CNT_W-1:0]  cfg_trail,
  input  logic              pkt_req,
  input  logic              pkt_valid,
  input  logic              pkt_last,
  input  logic [DW-1:0]     pkt_data,
  output logic              pkt_ready,
  output logic [DW-1:0]     tx_data,
  output logic              tx_strobe,
  output logic [2:0]        clk_lane,
  output logic [2:0]        dat_lane,
  output logic              init_done
);
  import dphy_seq_pkg::*;

  seq_state_e       state;
  lane_code_e       clk_code, dat_code;
  logic             timer_load, interval_over;
  logic [CNT_W-1:0] timer_val;
  logic             hs_accept, burst_done;

  seq_init_hold #(.INIT_W(INIT_W)) u_init (
    .clk(clk), .rst_n(rst_n), .cfg_cycles(cfg_init_cycles), .done(init_done)
  );

  seq_interval_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(timer_load), .load_val(timer_val),
    .expired(interval_over)
  );

  seq_lane_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cont_clk(cfg_cont_clk),
    .cfg_prep(cfg_prep), .cfg_zero(cfg_zero), .cfg_clk_pre(cfg_clk_pre),
    .cfg_clk_post(cfg_clk_post), .cfg_trail(cfg_trail),
    .init_done(init_done), .req(pkt_req), .burst_done(burst_done),
    .interval_over(interval_over), .state(state),
    .timer_load(timer_load), .timer_val(timer_val)
  );

  seq_lane_encode u_enc (
    .state(state), .cont_clk(cfg_cont_clk), .clk_code(clk_code), .dat_code(dat_code)
  );

  assign pkt_ready  = (state == SQ_D_HS);
  assign hs_accept  = pkt_ready & pkt_valid;
  assign burst_done = hs_accept & pkt_last;
  assign clk_lane   = clk_code;
  assign dat_lane   = dat_code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_data   <= '0;
      tx_strobe <= 1'b0;
    end else begin
      tx_strobe <= hs_accept;
      if (hs_accept) tx_data <= pkt_data;
    end
  end

endmodule

// File: rtl/dphy_seq_checker.sv
module dphy_seq_checker #(
  parameter int CNT_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_cont_clk,
  input logic [CNT_W-1:0] cfg_prep,
  input logic             init_done,
  input logic             pkt_ready,
  input logic             pkt_valid,
  input logic [2:0]       clk_lane,
  input logic [2:0]       dat_lane,
  input logic             tx_strobe
);
  import dphy_seq_pkg::*;

  logic [CNT_W:0] lp00_run;
  logic [CNT_W:0] prep_eff;

  assign prep_eff = (cfg_prep == '0) ? (CNT_W+1)'(1) : {1'b0, cfg_prep};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 lp00_run <= '0;
    else if (dat_lane == LN_LP00) lp00_run <= lp00_run + 1'b1;
    else                        lp00_run <= '0;
  end

  AST_NO_TRAFFIC_BEFORE_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> (!pkt_ready && dat_lane == LN_LP11)); // R1
  AST_INIT_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done); // R1
  AST_READY_IN_HS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_ready |-> (dat_lane == LN_HSDATA && clk_lane == LN_HSCLK)); // R5
  AST_STROBE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_ready && pkt_valid) |=> tx_strobe); // R5
  AST_CLOCK_UNDER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_lane != LN_LP11) |-> (clk_lane == LN_HSCLK)); // R3
  AST_ZERO_FOLLOWS_PREP: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_lane == LN_HS0 && $past(dat_lane) != LN_HS0) |-> ($past(dat_lane) == LN_LP00)); // R4
  AST_PREP_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_lane != LN_LP00 && $past(dat_lane) == LN_LP00) |-> (lp00_run == prep_eff)); // R9
  AST_TRAIL_TO_LP11: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_lane == LN_TRAIL) |=> (dat_lane == LN_TRAIL || dat_lane == LN_LP11)); // R6
  AST_CONT_CLOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_cont_clk && clk_lane == LN_HSCLK) |=> (clk_lane == LN_HSCLK)); // R7

endmodule

bind dphy_tx_sequencer dphy_seq_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_cont_clk(cfg_cont_clk), .cfg_prep(cfg_prep),
  .init_done(init_done), .pkt_ready(pkt_ready), .pkt_valid(pkt_valid),
  .clk_lane(clk_lane), .dat_lane(dat_lane), .tx_strobe(tx_strobe)
);

// File: tb/sim_dphy_tx_sequencer.sv
module sim_dphy_tx_sequencer;
  import dphy_seq_pkg::*;

  localparam int LANES = 4;
  localparam int DW    = 8 * LANES;
  localparam int CW    = 7;
  localparam int IW    = 15;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          cfg_cont_clk = 1'b0;
  logic [IW-1:0] cfg_init_cycles = '0;
  logic [CW-1:0] cfg_prep = '0, cfg_zero = '0, cfg_clk_pre = '0, cfg_clk_post = '0, cfg_trail = '0;
  logic          pkt_req = 1'b0, pkt_valid = 1'b0, pkt_last = 1'b0;
  logic [DW-1:0] pkt_data = '0;
  logic          pkt_ready, tx_strobe, init_done;
  logic [DW-1:0] tx_data;
  logic [2:0]    clk_lane, dat_lane;

  dphy_tx_sequencer #(.LANES(LANES), .CNT_W(CW), .INIT_W(IW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_cont_clk(cfg_cont_clk), .cfg_init_cycles(cfg_init_cycles),
    .cfg_prep(cfg_prep), .cfg_zero(cfg_zero), .cfg_clk_pre(cfg_clk_pre),
    .cfg_clk_post(cfg_clk_post), .cfg_trail(cfg_trail), .pkt_req(pkt_req),
    .pkt_valid(pkt_valid), .pkt_last(pkt_last), .pkt_data(pkt_data),
    .pkt_ready(pkt_ready), .tx_data(tx_data), .tx_strobe(tx_strobe),
    .clk_lane(clk_lane), .dat_lane(dat_lane), .init_done(init_done)
  );

  int checks = 0, errors = 0, cycles = 0;
  bit finished = 1'b0;
  int word_ix = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int         init_left;
  bit         m_done, steady;
  int         phase;            // 0 init hold, 1 idle, 2 high-speed payload
  bit [5:0]   plan_q[$];        // {clock code, data code} per upcoming cycle
  logic [2:0] e_clk, e_dat;
  bit         e_rdy, e_stb;
  logic [DW-1:0] e_data;

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic void plan(input int n, input logic [2:0] c, input logic [2:0] d);
    for (int k = 0; k < n; k++) plan_q.push_back({c, d});
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_left = eff(int'(cfg_init_cycles));
      m_done = 0; steady = 0; phase = 0; plan_q.delete();
      e_clk = LN_LP11; e_dat = LN_LP11; e_rdy = 0; e_stb = 0; e_data = '0;
    end else begin
      e_stb = e_rdy && pkt_valid;
      if (e_stb) e_data = pkt_data;
      if (phase == 0) begin
        if (!m_done) begin
          init_left--;
          if (init_left == 0) m_done = 1;
        end else if (cfg_cont_clk) begin
          plan(eff(int'(cfg_prep)), LN_LP00, LN_LP11);
          plan(eff(int'(cfg_zero)), LN_HS0, LN_LP11);
          phase = 1; steady = 0;
        end else begin
          phase = 1; steady = 1;
        end
      end else if (plan_q.size() == 0 && !steady) begin
        steady = 1;
      end else if (plan_q.size() == 0 && phase == 1 && pkt_req) begin
        if (!cfg_cont_clk) begin
          plan(eff(int'(cfg_prep)), LN_LP00, LN_LP11);
          plan(eff(int'(cfg_zero)), LN_HS0, LN_LP11);
          plan(eff(int'(cfg_clk_pre)), LN_HSCLK, LN_LP11);
        end
        plan(eff(int'(cfg_prep)), LN_HSCLK, LN_LP00);
        plan(eff(int'(cfg_zero)), LN_HSCLK, LN_HS0);
        phase = 2; steady = 0;
      end else if (plan_q.size() == 0 && phase == 2 && pkt_valid && pkt_last) begin
        plan(eff(int'(cfg_trail)), LN_HSCLK, LN_TRAIL);
        if (!cfg_cont_clk) begin
          plan(eff(int'(cfg_clk_post)), LN_HSCLK, LN_LP11);
          plan(eff(int'(cfg_trail)), LN_TRAIL, LN_LP11);
        end
        phase = 1; steady = 0;
      end
      if (plan_q.size() > 0) begin
        {e_clk, e_dat} = plan_q.pop_front();
        steady = 0;
      end else if (phase == 0) begin
        e_clk = LN_LP11; e_dat = LN_LP11;
      end else if (phase == 1) begin
        e_clk = cfg_cont_clk ? LN_HSCLK : LN_LP11; e_dat = LN_LP11;
      end else begin
        e_clk = LN_HSCLK; e_dat = LN_HSDATA;
      end
      e_rdy = (plan_q.size() == 0) && steady && (phase == 2) && (e_dat == LN_HSDATA);
    end
  end

  // Per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(init_done == m_done, "R1 init_done", 32'(init_done), 32'(m_done));
      chk(clk_lane == e_clk, "R2 R3 R6 R7 clock lane code", 32'(clk_lane), 32'(e_clk));
      chk(dat_lane == e_dat, "R2 R4 R8 data lane code", 32'(dat_lane), 32'(e_dat));
      chk(pkt_ready == e_rdy, "R5 ready", 32'(pkt_ready), 32'(e_rdy));
      chk(tx_strobe == e_stb, "R5 strobe", 32'(tx_strobe), 32'(e_stb));
      if (e_stb) chk(tx_data == e_data, "R5 payload word", tx_data, e_data);
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic do_reset(input bit cont, input int init, input int p, input int z,
                          input int pre, input int post, input int tr);
    rst_n = 0; pkt_req = 0; pkt_valid = 0; pkt_last = 0;
    cfg_cont_clk = cont; cfg_init_cycles = IW'(init);
    cfg_prep = CW'(p); cfg_zero = CW'(z); cfg_clk_pre = CW'(pre);
    cfg_clk_post = CW'(post); cfg_trail = CW'(tr);
    repeat (3) @(negedge clk);
    chk(!init_done, "R1 reset init_done", 32'(init_done), 0);
    chk(!pkt_ready && !tx_strobe, "R1 reset ready/strobe", 32'({pkt_ready, tx_strobe}), 0);
    chk(clk_lane == LN_LP11 && dat_lane == LN_LP11, "R1 reset lanes LP-11",
        32'({clk_lane, dat_lane}), 0);
    rst_n = 1;
  endtask

  task automatic burst(input int n, input bit keep, output int lat);
    int  i = 0, t = 0;
    bit  bub = 0, r;
    lat = -1;
    pkt_req = 1;
    while (i < n) begin
      if (lat < 0 && pkt_ready) lat = t;
      pkt_valid = 1;
      if (i == 1 && !bub && pkt_ready) begin pkt_valid = 0; bub = 1; end
      pkt_data = 32'hC0DE0000 + 32'(word_ix);
      pkt_last = (i == n - 1);
      r = pkt_ready;
      @(negedge clk);
      t++;
      if (r && pkt_valid) begin i++; word_ix++; end
    end
    pkt_valid = 0; pkt_last = 0;
    if (!keep) pkt_req = 0;
  endtask

  initial begin
    int lat, n;
    @(negedge clk);
    // Gated clock, request held through init hold and across the trail (R1, R3, R8)
    do_reset(0, 20, 3, 4, 2, 3, 5);
    pkt_req = 1;
    n = 0;
    while (!init_done && n < 100) begin @(negedge clk); n++; end
    chk(n == 20, "R1 init hold length", 32'(n), 20);
    burst(5, 1, lat);
    burst(3, 0, lat);
    repeat (40) @(negedge clk);
    // Continuous clock (R7)
    do_reset(1, 6, 2, 3, 4, 2, 3);
    repeat (20) @(negedge clk);
    burst(4, 0, lat);
    chk(lat == 6, "R7 continuous entry latency", 32'(lat), 6);
    burst(2, 0, lat);
    repeat (30) @(negedge clk);
    // All settings zero behave as one (R9)
    do_reset(0, 0, 0, 0, 0, 0, 0);
    repeat (5) @(negedge clk);
    burst(3, 0, lat);
    chk(lat == 6, "R9 zero settings entry latency", 32'(lat), 6);
    burst(1, 0, lat);
    repeat (20) @(negedge clk);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule